// File: doc/BRIEF.md
# Idle-Delay Refresh Scheduler

This block decides when one memory rank receives a refresh command. Refresh obligations build up as the periodic interval tick fires. When the rank becomes idle, the block does not refresh at once. It holds off for a delay window and watches whether demand traffic returns. Any demand request that arrives inside the window starts the window again. If the window runs out while the rank is still idle, one pending refresh is issued.

The window length adapts to the workload. The block keeps a running average of how long idle periods last. The window is that average scaled down linearly by how many refreshes are already owed. A rank that has fallen far behind therefore refreshes sooner. When the postponement budget is exhausted, the block issues a refresh at once, whatever the traffic. The refresh command itself is carried out elsewhere. This block only raises a one-cycle issue strobe and reports how many refreshes are still owed.

Top module: `idle_refresh_sched`

## Requirements
- R1: The owed count `pend_o` is 0 after reset. It rises by one on a clock edge where `tick_i` is high and no refresh issues. It falls by one on an edge where a refresh issues and `tick_i` is low. It stays unchanged when both happen in the same cycle.
- R2: When `pend_o` equals MAX_PEND (default 8), `ref_issue_o` is high in that cycle whatever the values of `idle_i` and `req_i`.
- R3: While `pend_o` is 0, `ref_issue_o` stays low, even during idle periods of any length.
- R4: Below the limit, `ref_issue_o` stays low in any cycle where `idle_i` is low or `req_i` is high.
- R5: The idle cycles of a window are numbered from 0, starting at the first idle cycle of the period or the first cycle after a restart. Below the limit, a refresh issues in the first idle, request-free cycle whose number k satisfies k >= floor(avg * (MAX_PEND - pend_o) / MAX_PEND). Here avg is the current idle-length average.
- R6: A cycle with `req_i` high during an idle period restarts the window. The next idle cycle is numbered 0.
- R7: Once a refresh has issued inside an idle period, no further refresh below the limit issues until `idle_i` has gone low and risen again.
- R8: The average resets to AVG_INIT (default 32). In the first cycle with `idle_i` low after an idle period of L cycles, it becomes avg - (avg >> AVG_SHIFT) + (L >> AVG_SHIFT), with AVG_SHIFT defaulting to 2.
- R9: `ref_issue_o` is a single-cycle strobe per issued refresh. Each cycle it is high removes exactly one owed refresh, as R1 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Refresh interval strobe; adds one owed refresh |
| req_i | input | 1 | Demand request arrival strobe for the rank |
| idle_i | input | 1 | High while the rank has no demand work |
| ref_issue_o | output | 1 | One-cycle strobe: issue one refresh now |
| pend_o | output | $clog2(MAX_PEND+1) | Number of owed refreshes |

## Verification
The delay window is swept over every owed count from 1 to 7, starting from the reset average. This separates the linear scaling of the threshold from a fixed delay and exposes any off-by-one in where the window ends. A series of idle periods of known lengths is then applied before a measured window. This shows whether the average follows the shift-weighted update, as opposed to staying at its reset value or taking the last period alone.

Idle runs are tested with a request injected partway, and with the owed count at zero. These tell a true restart apart from a pause, and show that the zero-owed case never issues. A busy, request-heavy phase that drives the count to the limit checks the forced path. That phase also checks the case where a tick lands in the same cycle as an issue.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  // Scale the idle average by (max - pend) / max, with max a power of two.
  function automatic int unsigned scaled_wait(input int unsigned avg,
                                              input int unsigned pend,
                                              input int unsigned max_pend,
                                              input int unsigned max_log2);
    int unsigned head;
    head = (pend >= max_pend) ? 0 : (max_pend - pend);
    return (avg * head) >> max_log2;
  endfunction

endpackage

// File: rtl/rfs_pend_ctr.sv
module rfs_pend_ctr #(
  parameter int MAX_PEND = 8,
  parameter int PEND_W   = $clog2(MAX_PEND + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              dec_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              full_o
);

  localparam logic [PEND_W-1:0] LIMIT = PEND_W'(MAX_PEND);

  logic [PEND_W-1:0] pend_q, pend_d;
  logic              pend_en;

  always_comb begin
    pend_d  = pend_q;
    pend_en = 1'b0;
    if (tick_i && !dec_i && (pend_q != LIMIT)) begin
      pend_d  = pend_q + 1'b1;
      pend_en = 1'b1;
    end else if (!tick_i && dec_i && (pend_q != '0)) begin
      pend_d  = pend_q - 1'b1;
      pend_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
  assign full_o = (pend_q == LIMIT);

endmodule

// File: rtl/rfs_idle_avg.sv
module rfs_idle_avg #(
  parameter int AVG_W     = 12,
  parameter int AVG_SHIFT = 2,
  parameter int AVG_INIT  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_i,
  output logic [AVG_W-1:0] avg_o
);

  localparam logic [AVG_W-1:0] LEN_SAT = {AVG_W{1'b1}};

  logic [AVG_W-1:0] len_q, len_d;
  logic [AVG_W-1:0] avg_q, avg_d;
  logic             len_en, avg_en;

  // Length of the running idle period, saturating.
  always_comb begin
    len_d  = len_q;
    len_en = 1'b0;
    if (idle_i) begin
      if (len_q != LEN_SAT) begin
        len_d  = len_q + 1'b1;
        len_en = 1'b1;
      end
    end else if (len_q != '0) begin
      len_d  = '0;
      len_en = 1'b1;
    end
  end

  // Moving average folded in on the first busy cycle after an idle period.
  always_comb begin
    avg_en = !idle_i && (len_q != '0);
    avg_d  = avg_q - (avg_q >> AVG_SHIFT) + (len_q >> AVG_SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_en) begin
      len_q <= len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_q <= AVG_W'(AVG_INIT);
    end else if (avg_en) begin
      avg_q <= avg_d;
    end
  end

  assign avg_o = avg_q;

endmodule

// File: rtl/rfs_delay_timer.sv
module rfs_delay_timer
  import rfs_pkg::*;
#(
  parameter int MAX_PEND = 8,
  parameter int PEND_W   = $clog2(MAX_PEND + 1),
  parameter int AVG_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_i,
  input  logic              req_i,
  input  logic              full_i,
  input  logic [PEND_W-1:0] pend_i,
  input  logic [AVG_W-1:0]  avg_i,
  output logic              issue_o
);

  localparam int          MAX_LOG2 = $clog2(MAX_PEND);
  localparam logic [AVG_W-1:0] WAIT_SAT = {AVG_W{1'b1}};

  logic [AVG_W-1:0] wait_q, wait_d;
  logic             wait_en;
  logic             spent_q, spent_d;
  logic             spent_en;
  logic [AVG_W-1:0] thr;
  logic             quiet;
  logic             elig;

  always_comb begin
    thr = AVG_W'(scaled_wait(int'(avg_i), int'(pend_i), MAX_PEND, MAX_LOG2));
  end

  assign quiet   = idle_i && !req_i;
  assign elig    = quiet && !spent_q && (pend_i != '0) && (wait_q >= thr);
  assign issue_o = full_i || elig;

  // Window counter: cleared by busy or request cycles.
  always_comb begin
    wait_d  = wait_q;
    wait_en = 1'b0;
    if (!quiet) begin
      if (wait_q != '0) begin
        wait_d  = '0;
        wait_en = 1'b1;
      end
    end else if (wait_q != WAIT_SAT) begin
      wait_d  = wait_q + 1'b1;
      wait_en = 1'b1;
    end
  end

  // One refresh per idle period; rearmed when the rank goes busy.
  always_comb begin
    spent_d  = spent_q;
    spent_en = 1'b0;
    if (!idle_i) begin
      spent_d  = 1'b0;
      spent_en = spent_q;
    end else if (issue_o) begin
      spent_d  = 1'b1;
      spent_en = !spent_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
    end else if (wait_en) begin
      wait_q <= wait_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spent_q <= 1'b0;
    end else if (spent_en) begin
      spent_q <= spent_d;
    end
  end

endmodule

// File: rtl/idle_refresh_sched.sv
module idle_refresh_sched #(
  parameter int MAX_PEND  = 8,
  parameter int AVG_W     = 12,
  parameter int AVG_SHIFT = 2,
  parameter int AVG_INIT  = 32,
  localparam int PEND_W   = $clog2(MAX_PEND + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              idle_i,
  output logic              ref_issue_o,
  output logic [PEND_W-1:0] pend_o
);

  logic              full;
  logic              issue;
  logic [PEND_W-1:0] pend;
  logic [AVG_W-1:0]  avg;

  rfs_pend_ctr #(
    .MAX_PEND (MAX_PEND),
    .PEND_W   (PEND_W)
  ) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .dec_i  (issue),
    .pend_o (pend),
    .full_o (full)
  );

  rfs_idle_avg #(
    .AVG_W     (AVG_W),
    .AVG_SHIFT (AVG_SHIFT),
    .AVG_INIT  (AVG_INIT)
  ) u_avg (
    .clk    (clk),
    .rst_n  (rst_n),
    .idle_i (idle_i),
    .avg_o  (avg)
  );

  rfs_delay_timer #(
    .MAX_PEND (MAX_PEND),
    .PEND_W   (PEND_W),
    .AVG_W    (AVG_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle_i  (idle_i),
    .req_i   (req_i),
    .full_i  (full),
    .pend_i  (pend),
    .avg_i   (avg),
    .issue_o (issue)
  );

  assign ref_issue_o = issue;
  assign pend_o      = pend;

endmodule

// File: rtl/idle_refresh_sched_chk.sv
module idle_refresh_sched_chk #(
  parameter int MAX_PEND = 8,
  parameter int PEND_W   = $clog2(MAX_PEND + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              req_i,
  input logic              idle_i,
  input logic              ref_issue_o,
  input logic [PEND_W-1:0] pend_o
);

  localparam logic [PEND_W-1:0] LIMIT = PEND_W'(MAX_PEND);

  p_pend_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o <= LIMIT);

  p_pend_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ref_issue_o) |=> (pend_o == $past(pend_o) + 1'b1));

  p_pend_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_issue_o && !tick_i) |=> (pend_o == $past(pend_o) - 1'b1));

  p_pend_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_issue_o == tick_i) |=> $stable(pend_o));

  p_force_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o == LIMIT) |-> ref_issue_o);

  p_zero_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o == '0) |-> !ref_issue_o);

  p_busy_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((!idle_i || req_i) && (pend_o != LIMIT)) |-> !ref_issue_o);

endmodule

bind idle_refresh_sched idle_refresh_sched_chk #(
  .MAX_PEND (MAX_PEND),
  .PEND_W   (PEND_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .req_i       (req_i),
  .idle_i      (idle_i),
  .ref_issue_o (ref_issue_o),
  .pend_o      (pend_o)
);

// File: tb/idle_refresh_sched_bench.sv
module idle_refresh_sched_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAXP       = 8;
  localparam int AINIT      = 32;
  localparam int ASH        = 2;
  localparam int PW         = $clog2(MAXP + 1);

  logic          clk;
  logic          rst_n;
  logic          tick_i;
  logic          req_i;
  logic          idle_i;
  logic          ref_issue_o;
  logic [PW-1:0] pend_o;

  int checks;
  int errors;
  int cycles;
  bit done;

  idle_refresh_sched u_idle_refresh_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .req_i       (req_i),
    .idle_i      (idle_i),
    .ref_issue_o (ref_issue_o),
    .pend_o      (pend_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic report();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge; sample the strobe before the rise.
  task automatic cyc(input bit t, input bit r, input bit i, output bit iss);
    tick_i = t;
    req_i  = r;
    idle_i = i;
    #1;
    iss = ref_issue_o;
    @(negedge clk);
  endtask

  task automatic do_reset();
    tick_i = 1'b0;
    req_i  = 1'b0;
    idle_i = 1'b0;
    rst_n  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load(input int n);
    bit s;
    for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 1'b0, s);
  endtask

  // Stay idle until a strobe; return the 0-based idle cycle of the strobe.
  task automatic idle_until(input int limit, output int at);
    bit s;
    at = -1;
    for (int k = 0; k < limit; k++) begin
      cyc(1'b0, 1'b0, 1'b1, s);
      if (s && at < 0) at = k;
      if (s) break;
    end
  endtask

  function automatic int thr_of(input int avg, input int pend);
    return (avg * (MAXP - pend)) / MAXP;
  endfunction

  initial begin
    bit s;
    int at;
    int a;
    int extra;
    int lens[3];
    checks = 0;
    errors = 0;
    cycles = 0;
    done   = 1'b0;

    // Reset state
    do_reset();
    chk("R1 reset pend", int'(pend_o), 0);
    cyc(1'b0, 1'b0, 1'b0, s);
    chk("R1 reset issue", int'(s), 0);

    // Zero owed: long idle never issues (R3)
    at = 0;
    for (int k = 0; k < 100; k++) begin
      cyc(1'b0, 1'b0, 1'b1, s);
      at = at + int'(s);
    end
    chk("R3 no issue at zero owed", at, 0);

    // Window sweep over owed count, reset average (R5, R1, R9, R7)
    for (int p = 1; p < MAXP; p++) begin
      do_reset();
      load(p);
      chk("R1 count after ticks", int'(pend_o), p);
      idle_until(400, at);
      chk("R5 window end", at, thr_of(AINIT, p));
      chk("R9 one removed", int'(pend_o), p - 1);
      extra = 0;
      for (int k = 0; k < 80; k++) begin
        cyc(1'b0, 1'b0, 1'b1, s);
        extra = extra + int'(s);
      end
      chk("R7 single issue per idle period", extra, 0);
      chk("R7 owed unchanged", int'(pend_o), p - 1);
    end

    // Busy cycles block issue below the limit (R4)
    do_reset();
    load(5);
    extra = 0;
    for (int k = 0; k < 60; k++) begin
      cyc(1'b0, (k % 3) == 0, (k % 2) == 0 && (k % 3) == 0, s);
      extra = extra + int'(s);
    end
    chk("R4 no issue when busy or requesting", extra, 0);

    // Request restarts window (R6)
    do_reset();
    load(1);
    for (int k = 0; k < 10; k++) cyc(1'b0, 1'b0, 1'b1, s);
    cyc(1'b0, 1'b1, 1'b1, s);
    chk("R4 no issue in request cycle", int'(s), 0);
    idle_until(400, at);
    chk("R6 window restart", at, thr_of(AINIT, 1));

    // Average tracking (R8)
    do_reset();
    lens[0] = 8;
    lens[1] = 20;
    lens[2] = 40;
    a = AINIT;
    foreach (lens[j]) begin
      for (int k = 0; k < lens[j]; k++) cyc(1'b0, 1'b0, 1'b1, s);
      cyc(1'b0, 1'b0, 1'b0, s);
      a = a - (a >> ASH) + (lens[j] >> ASH);
    end
    load(4);
    idle_until(400, at);
    chk("R8 average drives window", at, thr_of(a, 4));

    // Forced issue at the limit, with tick collision (R2, R1)
    do_reset();
    load(MAXP);
    chk("R2 count at limit", int'(pend_o), MAXP);
    cyc(1'b1, 1'b1, 1'b0, s);
    chk("R2 forced issue with request", int'(s), 1);
    chk("R1 tick and issue hold", int'(pend_o), MAXP);
    cyc(1'b0, 1'b1, 1'b0, s);
    chk("R2 forced again", int'(s), 1);
    chk("R9 forced removes one", int'(pend_o), MAXP - 1);
    cyc(1'b0, 1'b1, 1'b0, s);
    chk("R4 below limit busy", int'(s), 0);

    done = 1'b1;
    report();
  end

endmodule